// File: doc/BRIEF.md
# Cross-Timestamp Snapshot Unit

This unit takes an atomic snapshot of three free-running counts for one DMA stream when software requests it. The three counts are a wall-clock frame count, a 64-bit system time input and the 64-bit link position of the selected stream. The wall clock is generated inside the unit. It advances once per clock, and the clock is meant to run at 24 MHz, which gives a resolution of roughly 42 ns. It has a cycles-in-frame field that runs from 0 to 499, one 48 kHz frame, and a frame count that steps each time that field wraps.

Software picks a stream with a direction bit and a channel index. The channel index is the stream tag minus one, because tag zero is never assigned. Software then sets the initiate bit. All three counts are latched on the same clock edge, and a done bit then reports that the snapshot is valid. The snapshot stays frozen until software acknowledges it through the control register. Snapshots taken within ten cycles of either end of a frame are marked as unreliable, so that software can retry them. Converting the counts to time units is left to software.

Top module: `xts_snap_unit`

## Requirements
- R1: After reset, every readable word is zero: control (address 0), wall snapshot (1), system time low and high (2, 3) and link position low and high (4, 5).
- R2: The control word stores the channel index in bits [CH_W-1:0] (bits [1:0] with four streams) and the direction in bit 7 (1 = playback, 0 = capture). Both read back as written while no capture is running. Bits 6 down to CH_W are not stored and read as zero.
- R3: A control write with bit 8 set starts a capture if no capture is running and done is clear. Bit 8 reads 1 for as long as the capture is in progress.
- R4: All three counts are latched on the second clock edge after the edge that samples the initiate write. Done (bit 9) reads 1 from the edge after the latch, at which point bit 8 reads 0.
- R5: Wall snapshot layout: bits [8:0] hold cycles-in-frame and bits [31:9] hold the frame count. Cycles-in-frame starts at 0 after reset and advances once per clock. After 499 it returns to 0 and the frame count increments.
- R6: Addresses 2 and 3 return the low and high words of the latched system time. Addresses 4 and 5 return the low and high words of the latched position of the selected stream and direction.
- R7: While done is set, the snapshot words do not change. An initiate write that does not also set bit 9 is ignored.
- R8: Writing bit 9 as 1 to the control word while idle clears done. A single write that sets both bit 8 and bit 9 clears done and starts a new capture.
- R9: Control bit 10 holds a frame-edge flag that is latched with the snapshot. It is 1 when the latched cycles-in-frame is at most 10 or at least 489, and 0 otherwise.
- R10: Addresses 6 and 7 read as zero, and the read data is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the wall clock advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| sys_time | input | 64 | Free-running system time count |
| play_pos | input | NUM_STREAMS*64 | Playback stream link positions, stream i at bits [i*64 +: 64] |
| cap_pos | input | NUM_STREAMS*64 | Capture stream link positions, stream i at bits [i*64 +: 64] |

## Verification
Acknowledging an old snapshot and requesting a new one can fall on the same write. The bench provokes this with a control write that sets both bit 9 and bit 8. It judges the result by checking that done drops, that the busy bit rises, and that fresh values of the newly selected stream appear two edges later. A second collision is a capture that lands exactly on the frame wrap: the wall counter steps on the same edge that the snapshot latches it. The bench times initiate writes so that the latch hits cycles-in-frame 499 and 0, and checks both the latched field and the frame count.

// File: rtl/xts_pkg.sv
package xts_pkg;
    localparam int CNT_W = 64;
    localparam int REG_W = 32;

    localparam logic [2:0] ADR_CTRL    = 3'd0;
    localparam logic [2:0] ADR_WALL    = 3'd1;
    localparam logic [2:0] ADR_SYS_LO  = 3'd2;
    localparam logic [2:0] ADR_SYS_HI  = 3'd3;
    localparam logic [2:0] ADR_LINK_LO = 3'd4;
    localparam logic [2:0] ADR_LINK_HI = 3'd5;

    localparam int BIT_DIR  = 7;
    localparam int BIT_INIT = 8;
    localparam int BIT_DONE = 9;
    localparam int BIT_EDGE = 10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_GRAB = 2'd2,
        PH_POST = 2'd3
    } xts_phase_e;
endpackage

// File: rtl/xts_wallclock.sv
module xts_wallclock #(
    parameter int CIF_MAX = 499,
    parameter int CIF_W   = 9,
    parameter int FRM_W   = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CIF_W-1:0] cif_o,
    output logic [FRM_W-1:0] frm_o
);
    typedef struct packed {
        logic [CIF_W-1:0] cif;
        logic [FRM_W-1:0] frm;
    } wc_t;

    wc_t wc_d, wc_q;

    always_comb begin
        wc_d = wc_q;
        if (wc_q.cif == CIF_W'(CIF_MAX)) begin
            wc_d.cif = '0;
            wc_d.frm = wc_q.frm + 1'b1;
        end else begin
            wc_d.cif = wc_q.cif + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wc_q <= '0;
        else        wc_q <= wc_d;
    end

    assign cif_o = wc_q.cif;
    assign frm_o = wc_q.frm;

    // R5
    cif_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wc_q.cif <= CIF_W'(CIF_MAX));

    // R5
    cif_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wc_q.cif == CIF_W'(CIF_MAX)) |=>
            (wc_q.cif == '0) && (wc_q.frm == FRM_W'($past(wc_q.frm) + 1'b1)));
endmodule

// File: rtl/xts_pos_select.sv
module xts_pos_select #(
    parameter int NUM_STREAMS = 4,
    parameter int CH_W        = 2,
    parameter int POS_W       = 64
) (
    input  logic [NUM_STREAMS*POS_W-1:0] play_pos_i,
    input  logic [NUM_STREAMS*POS_W-1:0] cap_pos_i,
    input  logic                         sel_dir_i,
    input  logic [CH_W-1:0]              sel_ch_i,
    output logic [POS_W-1:0]             pos_o
);
    logic [POS_W-1:0] play_a [NUM_STREAMS];
    logic [POS_W-1:0] cap_a  [NUM_STREAMS];

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_unpack
        assign play_a[g] = play_pos_i[g*POS_W +: POS_W];
        assign cap_a[g]  = cap_pos_i[g*POS_W +: POS_W];
    end

    always_comb begin
        pos_o = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (CH_W'(i) == sel_ch_i) pos_o = sel_dir_i ? play_a[i] : cap_a[i];
        end
    end
endmodule

// File: rtl/xts_snap_unit.sv
module xts_snap_unit
    import xts_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int CIF_MAX     = 499,
    parameter int GUARD       = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [2:0]                   reg_addr,
    input  logic [REG_W-1:0]             reg_wdata,
    output logic [REG_W-1:0]             reg_rdata,
    input  logic [CNT_W-1:0]             sys_time,
    input  logic [NUM_STREAMS*CNT_W-1:0] play_pos,
    input  logic [NUM_STREAMS*CNT_W-1:0] cap_pos
);
    localparam int CH_W  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;
    localparam int CIF_W = $clog2(CIF_MAX + 1);
    localparam int FRM_W = REG_W - CIF_W;

    typedef struct packed {
        xts_phase_e       phase;
        logic             done;
        logic             dir;
        logic [CH_W-1:0]  ch;
        logic [REG_W-1:0] wall;
        logic [CNT_W-1:0] sys;
        logic [CNT_W-1:0] link;
        logic             edge_flag;
    } snap_t;

    snap_t s_d, s_q;

    logic [CIF_W-1:0] cif;
    logic [FRM_W-1:0] frm;
    logic [CNT_W-1:0] sel_pos;
    logic             wr_ctrl;
    logic             unused_wdata;

    xts_wallclock #(
        .CIF_MAX (CIF_MAX),
        .CIF_W   (CIF_W),
        .FRM_W   (FRM_W)
    ) u_wall (
        .clk   (clk),
        .rst_n (rst_n),
        .cif_o (cif),
        .frm_o (frm)
    );

    xts_pos_select #(
        .NUM_STREAMS (NUM_STREAMS),
        .CH_W        (CH_W),
        .POS_W       (CNT_W)
    ) u_sel (
        .play_pos_i (play_pos),
        .cap_pos_i  (cap_pos),
        .sel_dir_i  (s_q.dir),
        .sel_ch_i   (s_q.ch),
        .pos_o      (sel_pos)
    );

    assign wr_ctrl      = reg_wr && (reg_addr == ADR_CTRL);
    assign unused_wdata = ^reg_wdata;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_WAIT: s_d.phase = PH_GRAB;
            PH_GRAB: begin
                s_d.wall      = {frm, cif};
                s_d.sys       = sys_time;
                s_d.link      = sel_pos;
                s_d.edge_flag = (cif <= CIF_W'(GUARD)) ||
                                (cif >= CIF_W'(CIF_MAX - GUARD));
                s_d.phase     = PH_POST;
            end
            PH_POST: begin
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
            end
            default: begin
                if (wr_ctrl) begin
                    s_d.ch  = reg_wdata[CH_W-1:0];
                    s_d.dir = reg_wdata[BIT_DIR];
                    if (reg_wdata[BIT_DONE]) s_d.done = 1'b0;
                    if (reg_wdata[BIT_INIT] && (!s_q.done || reg_wdata[BIT_DONE]))
                        s_d.phase = PH_WAIT;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                ADR_CTRL: begin
                    reg_rdata[CH_W-1:0] = s_q.ch;
                    reg_rdata[BIT_DIR]  = s_q.dir;
                    reg_rdata[BIT_INIT] = (s_q.phase != PH_IDLE);
                    reg_rdata[BIT_DONE] = s_q.done;
                    reg_rdata[BIT_EDGE] = s_q.edge_flag;
                end
                ADR_WALL:    reg_rdata = s_q.wall;
                ADR_SYS_LO:  reg_rdata = s_q.sys[REG_W-1:0];
                ADR_SYS_HI:  reg_rdata = s_q.sys[CNT_W-1:REG_W];
                ADR_LINK_LO: reg_rdata = s_q.link[REG_W-1:0];
                ADR_LINK_HI: reg_rdata = s_q.link[CNT_W-1:REG_W];
                default:     reg_rdata = '0;
            endcase
        end
    end

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |-> !s_q.done);

    // R4
    grab_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_GRAB) |=> (s_q.phase == PH_POST) ##1 s_q.done);

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> ($stable(s_q.sys) && $stable(s_q.link) && $stable(s_q.wall)));

    // R7
    init_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && wr_ctrl && reg_wdata[BIT_INIT] && !reg_wdata[BIT_DONE])
            |=> (s_q.phase == PH_IDLE) && s_q.done);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[BIT_DONE] && (s_q.phase == PH_IDLE)) |=> !s_q.done);
endmodule

// File: tb/xts_snap_unit_bench.sv
module xts_snap_unit_bench;
    localparam int NS      = 4;
    localparam int CIF_MAX = 499;
    localparam int GUARD   = 10;
    localparam int WDOG    = 60000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b1;
    logic [2:0]        reg_addr = 3'd0;
    logic [31:0]       reg_wdata = 32'd0;
    logic [31:0]       reg_rdata;
    logic [63:0]       sys_time = 64'd0;
    logic [NS*64-1:0]  play_pos = '0;
    logic [NS*64-1:0]  cap_pos = '0;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int drv_n = 0;
    bit chk_on = 1'b0;

    // reference model state
    int          m_phase, m_ch, m_cif, m_frm;
    bit          m_done, m_dir, m_flag;
    logic [31:0] m_wall;
    logic [63:0] m_sys, m_link;

    xts_snap_unit #(.NUM_STREAMS(NS), .CIF_MAX(CIF_MAX), .GUARD(GUARD)) u_xts_snap_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_time(sys_time), .play_pos(play_pos), .cap_pos(cap_pos)
    );

    always #4 clk = ~clk;

    function automatic logic [63:0] posval(bit d, int i, int c);
        return {8'(d * 16 + i + 1), 24'(c), 32'(c * 5 + i * 1000)};
    endfunction

    always @(negedge clk) begin
        #1;
        sys_time <= 64'h0123_4567_0000_0000 + 64'(drv_n) * 64'h1_0000_0003;
        for (int i = 0; i < NS; i++) begin
            play_pos[i*64 +: 64] <= posval(1'b1, i, drv_n);
            cap_pos[i*64 +: 64]  <= posval(1'b0, i, drv_n);
        end
        drv_n++;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_ch = 0; m_cif = 0; m_frm = 0;
            m_done = 0; m_dir = 0; m_flag = 0;
            m_wall = '0; m_sys = '0; m_link = '0;
        end else begin
            bit dn;
            dn = m_done;
            case (m_phase)
                1: m_phase = 2;
                2: begin
                    m_wall = (32'(m_frm) << 9) | 32'(m_cif);
                    m_sys  = sys_time;
                    m_link = m_dir ? play_pos[m_ch*64 +: 64] : cap_pos[m_ch*64 +: 64];
                    m_flag = (m_cif <= GUARD) || (m_cif >= CIF_MAX - GUARD);
                    m_phase = 3;
                end
                3: begin m_done = 1; m_phase = 0; end
                default: begin
                    if (reg_wr && reg_addr == 3'd0) begin
                        m_ch  = int'(reg_wdata[1:0]);
                        m_dir = reg_wdata[7];
                        if (reg_wdata[9]) m_done = 0;
                        if (reg_wdata[8] && (!dn || reg_wdata[9])) m_phase = 1;
                    end
                end
            endcase
            if (m_cif == CIF_MAX) begin m_cif = 0; m_frm++; end
            else m_cif++;
        end
    end

    function automatic logic [31:0] mread(logic [2:0] a);
        logic [31:0] v;
        v = '0;
        if (reg_rd) begin
            case (a)
                3'd0: v = 32'(m_ch) | (32'(m_dir) << 7) | (32'(m_phase != 0) << 8)
                          | (32'(m_done) << 9) | (32'(m_flag) << 10);
                3'd1: v = m_wall;
                3'd2: v = m_sys[31:0];
                3'd3: v = m_sys[63:32];
                3'd4: v = m_link[31:0];
                3'd5: v = m_link[63:32];
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (chk_on && rst_n) chk("R5 R6 model compare", reg_rdata, mread(reg_addr));
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            tests++; fails++;
            $display("FAIL watchdog all-R act=%0d exp<%0d", cyc, WDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, string tag, logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        #1;
    endtask

    task automatic cap(logic [31:0] d, output logic [63:0] s, output logic [63:0] l);
        logic [31:0] old_lo;
        old_lo = m_sys[31:0];
        wr(3'd0, d);
        reg_addr = 3'd2;
        @(negedge clk);
        chk("R4 not latched after first edge", reg_rdata, old_lo);
        #1 reg_addr = 3'd0;
        @(negedge clk);
        s = sys_time;
        l = d[7] ? play_pos[int'(d[1:0])*64 +: 64] : cap_pos[int'(d[1:0])*64 +: 64];
        chk("R3 busy while capturing", 32'(reg_rdata[9:8]), 32'b01);
        #1 reg_addr = 3'd2;
        @(negedge clk);
        chk("R4 latched on second edge", reg_rdata, s[31:0]);
        #1 reg_addr = 3'd0;
        @(negedge clk);
        chk("R4 done after latch", 32'(reg_rdata[9:8]), 32'b10);
        #1;
    endtask

    task automatic snap_chk(logic [63:0] s, logic [63:0] l);
        rd(3'd2, "R6 sys low", s[31:0]);
        rd(3'd3, "R6 sys high", s[63:32]);
        rd(3'd4, "R6 link low", l[31:0]);
        rd(3'd5, "R6 link high", l[63:32]);
    endtask

    task automatic grab_at(int target, logic [31:0] sel);
        int ef;
        bit fl;
        do @(negedge clk); while (m_cif != (target + CIF_MAX - 1) % (CIF_MAX + 1));
        ef = m_frm + ((m_cif + 2 > CIF_MAX) ? 1 : 0);
        fl = (target <= GUARD) || (target >= CIF_MAX - GUARD);
        #1;
        wr(3'd0, 32'h300 | sel);
        repeat (3) @(negedge clk);
        #1;
        rd(3'd1, "R5 wall cycles and frame", (32'(ef) << 9) | 32'(target));
        rd(3'd0, "R9 frame-edge flag", sel | 32'h200 | (32'(fl) << 10));
    endtask

    initial begin
        logic [63:0] s1, l1, s2, l2;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;
        for (int a = 0; a < 6; a++) rd(3'(a), "R1 reset value", 32'd0);

        wr(3'd0, 32'h82);
        rd(3'd0, "R2 select readback", 32'h82);
        wr(3'd0, 32'h7F);
        rd(3'd0, "R2 unstored bits", 32'h03);

        cap(32'h182, s1, l1);
        snap_chk(s1, l1);

        wr(3'd0, 32'h182);
        repeat (4) @(negedge clk);
        #1;
        rd(3'd2, "R7 snapshot held", s1[31:0]);
        rd(3'd0, "R7 initiate ignored while done", 32'h282);

        wr(3'd0, 32'h282);
        rd(3'd0, "R8 ack clears done", 32'h082);

        cap(32'h100, s2, l2);
        snap_chk(s2, l2);
        cap(32'h383, s2, l2);
        rd(3'd0, "R8 ack plus initiate", 32'h283);
        snap_chk(s2, l2);

        grab_at(10, 32'h81);
        grab_at(11, 32'h81);
        grab_at(488, 32'h02);
        grab_at(489, 32'h02);
        grab_at(499, 32'h80);
        grab_at(0, 32'h80);

        rd(3'd6, "R10 unused address", 32'd0);
        rd(3'd7, "R10 unused address", 32'd0);
        reg_rd = 1'b0;
        rd(3'd2, "R10 read strobe low", 32'd0);
        reg_rd = 1'b1;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule